// File: doc/BRIEF.md
# Keyed Flash Erase Sequence Controller

This block guards the erase path of an on-chip flash array. It snoops the processor's special-register write bus and only issues an erase command to the flash when a set-up write has been followed by the matching key byte. A page erase needs a page number loaded first and then the page key. A mass erase needs an enable bit set first and then the mass key, and it is refused unless the debug port is enabled. Every rejected key write raises a one-cycle error pulse instead of an erase.

The same block also gates ordinary processor writes into flash. They pass only while the compute engine is stopped and the flash is idle. The erase outputs are single-cycle strobes. They are meant to drive a flash controller that holds `flash_busy` high while it works.

Top module: `flash_erase_guard`

## Requirements
- R1: After reset `pg_erase`, `mass_erase` and `err` are low and nothing is armed. A page key (0x55) written first thing after reset gives an error pulse.
- R2: A write to the page register (address 0x31) loads the page number from data bits [7:1] and arms page erase. A later write of 0x55 to the key register (address 0x32) raises `pg_erase` for one cycle, in the cycle after the key write, with `erase_page` equal to that number. The write also disarms page erase.
- R3: Bit 1 of a write to the control register (address 0x30) sets or clears the mass-erase enable. With the enable set and `dbg_en` high, a key write of 0xAA raises `mass_erase` for one cycle, in the cycle after the key write.
- R4: A key write of 0xAA while `dbg_en` is low gives an error and no erase. Every 0xAA key write clears the mass-erase enable, whether or not it erases.
- R5: A key write of any value other than 0x55 or 0xAA gives an error and clears both the page arm and the mass-erase enable.
- R6: A key write while `flash_busy` is high gives an error, erases nothing and leaves the armed state unchanged.
- R7: A key write while `eng_run` is high gives an error, erases nothing and clears both armed states.
- R8: `fwr_en` equals `fwr_req` in the same cycle when `eng_run` and `flash_busy` are both low. Otherwise `fwr_en` is low.
- R9: A key write of 0x55 with no page armed, or of 0xAA with the mass-erase enable clear, gives an error.
- R10: Every key write produces exactly one one-cycle pulse on exactly one of `pg_erase`, `mass_erase` or `err`, one cycle after the write. Writes to other addresses produce none. At most one of the three is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Special-register write strobe |
| reg_addr | input | 8 | Special-register write address |
| reg_wdata | input | 8 | Special-register write data |
| dbg_en | input | 1 | Debug port enabled; required for mass erase |
| eng_run | input | 1 | Compute engine is running |
| flash_busy | input | 1 | Flash array is busy with an operation |
| fwr_req | input | 1 | Processor request to write flash |
| fwr_en | output | 1 | Gated flash write enable |
| pg_erase | output | 1 | One-cycle page-erase command |
| mass_erase | output | 1 | One-cycle mass-erase command |
| erase_page | output | 7 | Page number for the page-erase command |
| err | output | 1 | One-cycle rejected-key pulse |

## Verification
The bench targets the arm-clearing rules. It repeats a key after a successful page erase, retries a mass key after one refused for a disabled debug port, and sends a valid key after a wrong key. A design that kept its armed state through any of these would issue an erase where an error is expected. A busy-flash key write is followed by a valid key, so a design that cleared the arm on busy would report an error instead of the page erase. The bench also loads page numbers 0 and 127, and control bytes that have every bit except the enable bit set, to catch a shifted field or a wrong enable bit.

// File: rtl/flash_erase_guard_pkg.sv
// Shared types for the keyed flash erase guard.
// Assumes: one decision per clock; the key register sees at most one write per cycle.
package flash_erase_guard_pkg;
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PAGE = 2'd1,
        ACT_MASS = 2'd2,
        ACT_ERR  = 2'd3
    } act_e;
endpackage

// File: rtl/feg_decode.sv
// Address decoder: turns a register write into one hit line per register.
// Assumes the three addresses are distinct.
module feg_decode #(
    parameter int          AW        = 8,
    parameter logic [AW-1:0] ADDR_CTRL = 8'h30,
    parameter logic [AW-1:0] ADDR_PAGE = 8'h31,
    parameter logic [AW-1:0] ADDR_KEY  = 8'h32
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          hit_ctrl,
    output logic          hit_page,
    output logic          hit_key
);
    // Compare the address against each register slot.
    always_comb begin
        hit_ctrl = wr && (addr == ADDR_CTRL);
        hit_page = wr && (addr == ADDR_PAGE);
        hit_key  = wr && (addr == ADDR_KEY);
    end
endmodule

// File: rtl/feg_arm.sv
// Armed-state store: holds the page number, the page arm and the mass enable.
// Assumes set and clear requests never coincide (they come from different addresses).
module feg_arm #(
    parameter int DW      = 8,
    parameter int MEN_BIT = 1,
    localparam int PW     = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_ctrl,
    input  logic          hit_page,
    input  logic [DW-1:0] wdata,
    input  logic          clr_page,
    input  logic          clr_mass,
    output logic          page_armed,
    output logic          mass_en,
    output logic [PW-1:0] page_q
);
    // Load the page field and the page arm, or drop the arm on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_armed <= 1'b0;
            page_q     <= '0;
        end else if (hit_page) begin
            page_armed <= 1'b1;
            page_q     <= wdata[DW-1:1];
        end else if (clr_page) begin
            page_armed <= 1'b0;
        end
    end

    // Track the mass-erase enable bit, dropped after any mass attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mass_en <= 1'b0;
        end else if (hit_ctrl) begin
            mass_en <= wdata[MEN_BIT];
        end else if (clr_mass) begin
            mass_en <= 1'b0;
        end
    end
endmodule

// File: rtl/feg_judge.sv
// Key judge: decides what a key-register write does and registers the result.
// Assumes flash_busy outranks eng_run, which outranks the key value.
module feg_judge
    import flash_erase_guard_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [DW-1:0] PAGE_KEY = 8'h55,
    parameter logic [DW-1:0] MASS_KEY = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_key,
    input  logic [DW-1:0] wdata,
    input  logic          page_armed,
    input  logic          mass_en,
    input  logic          dbg_en,
    input  logic          eng_run,
    input  logic          flash_busy,
    output logic          clr_page,
    output logic          clr_mass,
    output logic          pg_erase,
    output logic          mass_erase,
    output logic          err
);
    act_e act;

    // Classify the key write and pick which armed states to drop.
    always_comb begin
        act      = ACT_NONE;
        clr_page = 1'b0;
        clr_mass = 1'b0;
        if (hit_key) begin
            if (flash_busy) begin
                act = ACT_ERR;
            end else if (eng_run) begin
                act      = ACT_ERR;
                clr_page = 1'b1;
                clr_mass = 1'b1;
            end else if (wdata == PAGE_KEY) begin
                act      = page_armed ? ACT_PAGE : ACT_ERR;
                clr_page = page_armed;
            end else if (wdata == MASS_KEY) begin
                act      = (mass_en && dbg_en) ? ACT_MASS : ACT_ERR;
                clr_mass = 1'b1;
            end else begin
                act      = ACT_ERR;
                clr_page = 1'b1;
                clr_mass = 1'b1;
            end
        end
    end

    // Register the decision into single-cycle output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_erase   <= 1'b0;
            mass_erase <= 1'b0;
            err        <= 1'b0;
        end else begin
            pg_erase   <= (act == ACT_PAGE);
            mass_erase <= (act == ACT_MASS);
            err        <= (act == ACT_ERR);
        end
    end
endmodule

// File: rtl/flash_erase_guard.sv
// Keyed flash erase guard top: decodes register writes, keeps the armed
// state, judges key writes into erase strobes, and gates processor flash writes.
// Assumes the flash holds flash_busy high while it executes a command.
module flash_erase_guard #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter int          MEN_BIT   = 1,
    parameter logic [AW-1:0] ADDR_CTRL = 8'h30,
    parameter logic [AW-1:0] ADDR_PAGE = 8'h31,
    parameter logic [AW-1:0] ADDR_KEY  = 8'h32,
    parameter logic [DW-1:0] PAGE_KEY  = 8'h55,
    parameter logic [DW-1:0] MASS_KEY  = 8'hAA,
    localparam int PW = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          dbg_en,
    input  logic          eng_run,
    input  logic          flash_busy,
    input  logic          fwr_req,
    output logic          fwr_en,
    output logic          pg_erase,
    output logic          mass_erase,
    output logic [PW-1:0] erase_page,
    output logic          err
);
    logic hit_ctrl, hit_page, hit_key;
    logic clr_page, clr_mass;
    logic page_armed, mass_en;
    logic [PW-1:0] page_q;

    feg_decode #(.AW(AW), .ADDR_CTRL(ADDR_CTRL), .ADDR_PAGE(ADDR_PAGE), .ADDR_KEY(ADDR_KEY)) u_dec (
        .wr(reg_wr), .addr(reg_addr),
        .hit_ctrl(hit_ctrl), .hit_page(hit_page), .hit_key(hit_key)
    );

    feg_arm #(.DW(DW), .MEN_BIT(MEN_BIT)) u_arm (
        .clk(clk), .rst_n(rst_n), .hit_ctrl(hit_ctrl), .hit_page(hit_page),
        .wdata(reg_wdata), .clr_page(clr_page), .clr_mass(clr_mass),
        .page_armed(page_armed), .mass_en(mass_en), .page_q(page_q)
    );

    feg_judge #(.DW(DW), .PAGE_KEY(PAGE_KEY), .MASS_KEY(MASS_KEY)) u_judge (
        .clk(clk), .rst_n(rst_n), .hit_key(hit_key), .wdata(reg_wdata),
        .page_armed(page_armed), .mass_en(mass_en), .dbg_en(dbg_en),
        .eng_run(eng_run), .flash_busy(flash_busy),
        .clr_page(clr_page), .clr_mass(clr_mass),
        .pg_erase(pg_erase), .mass_erase(mass_erase), .err(err)
    );

    // Present the stored page number alongside the erase strobe.
    always_comb erase_page = page_q;

    // Pass processor flash writes only with the engine stopped and flash idle.
    always_comb fwr_en = fwr_req && !eng_run && !flash_busy;
endmodule

// File: rtl/flash_erase_guard_chk.sv
// Property checker for the keyed flash erase guard, attached by bind.
// Assumes the default addresses and key values of the top module.
module flash_erase_guard_chk #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [AW-1:0] ADDR_KEY  = 8'h32,
    parameter logic [DW-1:0] PAGE_KEY  = 8'h55,
    parameter logic [DW-1:0] MASS_KEY  = 8'hAA
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          dbg_en,
    input logic          eng_run,
    input logic          flash_busy,
    input logic          fwr_en,
    input logic          pg_erase,
    input logic          mass_erase,
    input logic          err
);
    p_page_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pg_erase |-> $past(reg_wr && reg_addr == ADDR_KEY && reg_wdata == PAGE_KEY));

    p_mass_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mass_erase |-> $past(reg_wr && reg_addr == ADDR_KEY && reg_wdata == MASS_KEY));

    p_mass_needs_dbg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mass_erase |-> $past(dbg_en));

    p_no_erase_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_erase || mass_erase) |-> !$past(flash_busy));

    p_no_erase_engine_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_erase || mass_erase) |-> !$past(eng_run));

    p_write_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run || flash_busy) |-> !fwr_en);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pg_erase, mass_erase, err}));

    p_outcome_from_key_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_erase || mass_erase || err) |-> $past(reg_wr && reg_addr == ADDR_KEY));
endmodule

bind flash_erase_guard flash_erase_guard_chk #(
    .AW(AW), .DW(DW), .ADDR_KEY(ADDR_KEY), .PAGE_KEY(PAGE_KEY), .MASS_KEY(MASS_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dbg_en(dbg_en), .eng_run(eng_run),
    .flash_busy(flash_busy), .fwr_en(fwr_en), .pg_erase(pg_erase),
    .mass_erase(mass_erase), .err(err)
);

// File: tb/tb_flash_erase_guard.sv
// Scoreboard bench: the driver pushes one expected outcome per key write,
// and the monitor pops and compares each strobe as it appears.
module tb_flash_erase_guard;
    import flash_erase_guard_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic dbg_en = 1'b0, eng_run = 1'b0, flash_busy = 1'b0, fwr_req = 1'b0;
    logic fwr_en, pg_erase, mass_erase, err;
    logic [6:0] erase_page;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;
    bit [127:0] erased = '0;

    typedef struct {
        act_e       act;
        logic [6:0] pg;
        string      tag;
    } exp_t;
    exp_t q[$];

    flash_erase_guard dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dbg_en(dbg_en), .eng_run(eng_run),
        .flash_busy(flash_busy), .fwr_req(fwr_req), .fwr_en(fwr_en),
        .pg_erase(pg_erase), .mass_erase(mass_erase),
        .erase_page(erase_page), .err(err)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] d, input act_e a, input logic [6:0] pg, input string tag);
        exp_t e;
        e.act = a; e.pg = pg; e.tag = tag;
        q.push_back(e);
        wr(8'h32, d);
    endtask

    // Monitor: compare each outcome strobe with the head of the queue.
    always @(negedge clk) begin
        if (live && rst_n) begin
            if ($countones({pg_erase, mass_erase, err}) > 1) begin
                check(1'b0, "R10 more than one strobe", {pg_erase, mass_erase, err}, 0);
            end else if (pg_erase || mass_erase || err) begin
                act_e got;
                got = pg_erase ? ACT_PAGE : (mass_erase ? ACT_MASS : ACT_ERR);
                if (pg_erase) erased[erase_page] = 1'b1;
                if (q.size() == 0) begin
                    check(1'b0, "R10 unexpected strobe", int'(got), int'(ACT_NONE));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(got == e.act, e.tag, int'(got), int'(e.act));
                    if (e.act == ACT_PAGE)
                        check(erase_page == e.pg, {e.tag, " page"}, erase_page, e.pg);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pg_erase && !mass_erase && !err, "R1 reset outputs", {pg_erase, mass_erase, err}, 0);
        live = 1'b1;

        key(8'h55, ACT_ERR, 0, "R1 page key after reset");

        wr(8'h31, 8'h54);
        key(8'h55, ACT_PAGE, 7'h2A, "R2 page erase 0x2A");
        key(8'h55, ACT_ERR, 0, "R2 page arm cleared after erase");
        wr(8'h31, 8'hFF);
        key(8'h55, ACT_PAGE, 7'h7F, "R2 page erase top page");
        wr(8'h31, 8'h01);
        key(8'h55, ACT_PAGE, 7'h00, "R2 page erase page 0, bit 0 ignored");

        dbg_en = 1'b1;
        wr(8'h30, 8'h02);
        key(8'hAA, ACT_MASS, 0, "R3 mass erase");
        wr(8'h30, 8'hFD);
        key(8'hAA, ACT_ERR, 0, "R3 enable only in bit 1");

        dbg_en = 1'b0;
        wr(8'h30, 8'h02);
        key(8'hAA, ACT_ERR, 0, "R4 mass refused without debug");
        dbg_en = 1'b1;
        key(8'hAA, ACT_ERR, 0, "R4 enable cleared by refused attempt");

        wr(8'h30, 8'h00);
        key(8'hAA, ACT_ERR, 0, "R9 mass key without enable");

        wr(8'h31, 8'h20);
        wr(8'h30, 8'h02);
        key(8'h12, ACT_ERR, 0, "R5 wrong key");
        key(8'h55, ACT_ERR, 0, "R5 page arm cleared by wrong key");
        key(8'hAA, ACT_ERR, 0, "R5 mass enable cleared by wrong key");

        wr(8'h31, 8'h10);
        wr(8'h30, 8'h02);
        flash_busy = 1'b1;
        key(8'h55, ACT_ERR, 0, "R6 key while busy");
        flash_busy = 1'b0;
        key(8'h55, ACT_PAGE, 7'h08, "R6 page arm kept through busy");
        key(8'hAA, ACT_MASS, 0, "R6 mass enable kept through busy");

        wr(8'h31, 8'h30);
        eng_run = 1'b1;
        key(8'h55, ACT_ERR, 0, "R7 key while engine runs");
        eng_run = 1'b0;
        key(8'h55, ACT_ERR, 0, "R7 page arm cleared by engine-run attempt");

        @(negedge clk);
        fwr_req = 1'b1;
        #1 check(fwr_en == 1'b1, "R8 write passes when idle", fwr_en, 1);
        eng_run = 1'b1;
        #1 check(fwr_en == 1'b0, "R8 write blocked by engine", fwr_en, 0);
        eng_run = 1'b0; flash_busy = 1'b1;
        #1 check(fwr_en == 1'b0, "R8 write blocked by busy", fwr_en, 0);
        flash_busy = 1'b0; fwr_req = 1'b0;
        #1 check(fwr_en == 1'b0, "R8 no request", fwr_en, 0);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R10 every key write answered", q.size(), 0);
        check(erased[7'h2A] && erased[7'h7F] && erased[0] && erased[8] && !erased[7'h10],
              "R2 flash model pages erased", 0, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule